// File: doc/BRIEF.md
# Prioritized Nesting Interrupt Controller

This block gathers interrupt requests from 32 external lines, a timer line, a software-raised source and a non-maskable input. Each maskable source carries its own enable bit, pending bit, 3-bit level and 3-bit priority, all held in one 8-bit register. The block arbitrates among the pending, enabled sources and presents one vector number to the CPU. The CPU takes that vector with an acknowledge pulse and signals the end of its handler with an end-of-interrupt pulse.

A small stack records the level of every handler that is running. A new request interrupts the running handler only when its level is strictly greater than the level on top of the stack. When a handler ends while another eligible request is waiting, the controller hands that request over directly and reuses the finished handler's stack slot. The non-maskable input overrides every enable bit, level threshold and stack limit.

Vector numbering: external line i is vector i (0..31), the software source is vector 32, the timer is vector 33 and the non-maskable input is vector 34. The controller is a three-state machine:
- **S_IDLE**: no handler is running.
- **S_RUN**: at least one handler is running.
- **S_TAIL**: a one-cycle decision state entered on every end-of-interrupt. It either hands the slot over to the next request or pops the stack.

The transitions are:
- **S_IDLE→S_RUN**: a maskable vector is acknowledged.
- **S_RUN→S_RUN**: a nested acknowledge, or an end-of-interrupt that only retires the non-maskable handler.
- **S_RUN→S_TAIL**: an end-of-interrupt arrives while no non-maskable handler is active.
- **S_TAIL→S_RUN**: a handed-over vector is acknowledged, or the stack is popped and entries remain.
- **S_TAIL→S_IDLE**: the stack is popped from a depth of one.

Top module: `irq_nest_ctrl`

## Requirements
- R1: A high `ext_irq[i]` or `timer_irq` on a clock edge sets that source's pending bit, and the bit reads back at the next cycle. If an acknowledge clears the bit on the same edge, the request still sets it. The software source (vector 32) becomes pending only through a register write.
- R2: A source whose enable bit is 0 is never presented, even though its pending bit stays set and reads back as 1.
- R3: Among eligible sources, the higher level wins. On equal level the higher priority wins. On equal level and priority the lower vector number wins.
- R4: While handlers run (state S_RUN), a maskable source is presented only if its level is strictly above the level on top of the stack. Level 0 therefore never interrupts a running handler.
- R5: `irq_ack` while a maskable vector is presented outside S_TAIL does three things: it clears that source's pending bit, pushes its level onto the stack and raises `nest_depth` by one.
- R6: When `nest_depth` equals DEPTH (4) in S_RUN, no maskable source is presented.
- R7: `irq_eoi` in S_RUN moves to S_TAIL. If nothing eligible is pending there, the next edge pops the top entry and `nest_depth` drops by one.
- R8: In S_TAIL, a maskable source is eligible if its level is above the stack entry beneath the top, or any level at all when the depth is 1. The eligible source is presented with `irq_tail` high. Its acknowledge overwrites the top entry and leaves `nest_depth` unchanged.
- R9: A high `nmi` on a clock edge makes vector 34 presented from the next cycle. It overrides all enable bits, levels and the stack limit.
- R10: Acknowledging vector 34 leaves the stack untouched and blocks all maskable sources. The next `irq_eoi` only lifts that block.
- R11: Register address i (0..33) holds one source: bit 7 is pending, bit 6 is enable, bits 5:3 are level and bits 2:0 are priority. A write replaces all fields and reads return them. Addresses 34 and above read 0 and ignore writes.
- R12: A write that changes level or priority takes effect in arbitration from the next cycle.
- R13: After reset, all registers read 0, `irq_valid` is 0 and `nest_depth` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_irq | input | 32 | External request lines |
| timer_irq | input | 1 | Timer request line |
| nmi | input | 1 | Non-maskable request |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address (source index) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| irq_valid | output | 1 | A vector is presented |
| irq_vector | output | 6 | Presented vector number |
| irq_tail | output | 1 | Presented vector is a hand-over after end-of-interrupt |
| irq_ack | input | 1 | CPU takes the presented vector |
| irq_eoi | input | 1 | CPU finished its current handler |
| nest_depth | output | 3 | Number of maskable handlers on the stack |

## Verification
The checker enforces several rules on every cycle:
- A presented maskable vector out-ranks the stack top while handlers run.
- A full stack in S_RUN presents only the non-maskable vector.
- The `nmi` input forces vector 34 on the next cycle.
- An active non-maskable handler lets nothing else through.
- A nested acknowledge grows the depth by one, a hand-over acknowledge keeps it, and an end-of-interrupt never grows it.

Only the bench scenarios can show three things: that arbitration picks the right winner among many randomly configured sources, that pending bits read back correctly, and that a full nest/hand-over/unwind sequence yields the expected vectors in order.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

    localparam int LVL_W = 3;
    localparam int PRI_W = 3;

    // one source register: pend[7] en[6] lvl[5:3] pri[2:0]
    typedef struct packed {
        logic             pend;
        logic             en;
        logic [LVL_W-1:0] lvl;
        logic [PRI_W-1:0] pri;
    } src_cfg_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_TAIL = 2'd2
    } nest_state_t;

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_nest_pkg::*;
#(
    parameter int NUM_SRC = 34,
    parameter int AW      = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr,
    input  logic [AW-1:0]           reg_addr,
    input  logic [7:0]              reg_wdata,
    output logic [7:0]              reg_rdata,
    input  logic [NUM_SRC-1:0]      set_vec,
    input  logic [NUM_SRC-1:0]      clr_vec,
    output src_cfg_t [NUM_SRC-1:0]  cfg
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        src_cfg_t q;
        logic     hit;

        assign hit = reg_wr && (reg_addr == AW'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (hit) begin
                q <= src_cfg_t'(reg_wdata);
            end else begin
                // a new request wins over a same-cycle clear
                q.pend <= (q.pend & ~clr_vec[i]) | set_vec[i];
            end
        end

        assign cfg[i] = q;
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (reg_addr == AW'(i)) begin
                reg_rdata = cfg[i];
            end
        end
    end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_nest_pkg::*;
#(
    parameter int NUM_SRC = 34,
    parameter int IW      = 6
) (
    input  src_cfg_t [NUM_SRC-1:0] cfg,
    input  logic                   floor_en,
    input  logic [LVL_W-1:0]       floor_lvl,
    input  logic                   block,
    output logic                   win_valid,
    output logic [IW-1:0]          win_idx,
    output logic [LVL_W-1:0]       win_lvl
);

    logic [PRI_W-1:0] win_pri;
    logic             elig;
    logic             better;

    // linear scan: ascending index with strict compare keeps the lower index on ties
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_lvl   = '0;
        win_pri   = '0;
        elig      = 1'b0;
        better    = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            elig = cfg[i].en && cfg[i].pend && !block &&
                   (!floor_en || (cfg[i].lvl > floor_lvl));
            better = !win_valid || (cfg[i].lvl > win_lvl) ||
                     ((cfg[i].lvl == win_lvl) && (cfg[i].pri > win_pri));
            if (elig && better) begin
                win_valid = 1'b1;
                win_idx   = IW'(i);
                win_lvl   = cfg[i].lvl;
                win_pri   = cfg[i].pri;
            end
        end
    end

endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack
    import irq_nest_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int DW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             replace,
    input  logic [LVL_W-1:0] new_lvl,
    output logic [DW-1:0]    depth,
    output logic             full,
    output logic [LVL_W-1:0] top_lvl,
    output logic [LVL_W-1:0] below_lvl
);

    logic [DW-1:0]    depth_q;
    logic [LVL_W-1:0] ent [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_ent
        logic [LVL_W-1:0] q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (push && (depth_q == DW'(k))) begin
                q <= new_lvl;
            end else if (replace && (depth_q == DW'(k + 1))) begin
                q <= new_lvl;
            end
        end

        assign ent[k] = q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            depth_q <= '0;
        end else if (push && !full) begin
            depth_q <= depth_q + DW'(1);
        end else if (pop && (depth_q != '0)) begin
            depth_q <= depth_q - DW'(1);
        end
    end

    always_comb begin
        top_lvl   = '0;
        below_lvl = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (depth_q == DW'(k + 1)) top_lvl = ent[k];
        end
        for (int k = 0; k < DEPTH - 1; k++) begin
            if (depth_q == DW'(k + 2)) below_lvl = ent[k];
        end
    end

    assign depth = depth_q;
    assign full  = (depth_q == DW'(DEPTH));

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
    import irq_nest_pkg::*;
#(
    parameter int NUM_EXT = 32,
    parameter int DEPTH   = 4,
    localparam int NUM_SRC = NUM_EXT + 2,
    localparam int AW      = $clog2(NUM_SRC + 1),
    localparam int VW      = $clog2(NUM_SRC + 1),
    localparam int DW      = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EXT-1:0] ext_irq,
    input  logic               timer_irq,
    input  logic               nmi,
    input  logic               reg_wr,
    input  logic [AW-1:0]      reg_addr,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    output logic               irq_valid,
    output logic [VW-1:0]      irq_vector,
    output logic               irq_tail,
    input  logic               irq_ack,
    input  logic               irq_eoi,
    output logic [DW-1:0]      nest_depth
);

    localparam int IW      = $clog2(NUM_SRC);
    localparam int NMI_VEC = NUM_SRC;

    nest_state_t state_q, state_d;

    src_cfg_t [NUM_SRC-1:0] cfg;
    logic [NUM_SRC-1:0]     set_vec;
    logic [NUM_SRC-1:0]     clr_vec;

    logic             floor_en;
    logic [LVL_W-1:0] floor_lvl;
    logic             block;
    logic             win_valid;
    logic [IW-1:0]    win_idx;
    logic [LVL_W-1:0] win_lvl;

    logic             push, pop, replace;
    logic             full;
    logic [LVL_W-1:0] top_lvl, below_lvl;
    logic [DW-1:0]    depth;

    logic nmi_pend_q, nmi_active_q;
    logic take_nmi, take_src, eoi_ok;

    // software source has no hardware line
    assign set_vec = {timer_irq, 1'b0, ext_irq};

    irq_cfg_regs #(.NUM_SRC(NUM_SRC), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .set_vec   (set_vec),
        .clr_vec   (clr_vec),
        .cfg       (cfg)
    );

    irq_arbiter #(.NUM_SRC(NUM_SRC), .IW(IW)) u_arb (
        .cfg       (cfg),
        .floor_en  (floor_en),
        .floor_lvl (floor_lvl),
        .block     (block),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_lvl   (win_lvl)
    );

    irq_level_stack #(.DEPTH(DEPTH), .DW(DW)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (pop),
        .replace   (replace),
        .new_lvl   (win_lvl),
        .depth     (depth),
        .full      (full),
        .top_lvl   (top_lvl),
        .below_lvl (below_lvl)
    );

    // request taking: the non-maskable source always stands first
    assign take_nmi = irq_ack && nmi_pend_q;
    assign take_src = irq_ack && !nmi_pend_q && win_valid;
    assign eoi_ok   = irq_eoi && !irq_ack;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_clr
        assign clr_vec[i] = take_src && (win_idx == IW'(i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_pend_q   <= 1'b0;
            nmi_active_q <= 1'b0;
        end else begin
            nmi_pend_q <= (nmi_pend_q && !take_nmi) || nmi;
            if (take_nmi) begin
                nmi_active_q <= 1'b1;
            end else if (eoi_ok && nmi_active_q) begin
                nmi_active_q <= 1'b0;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (take_src) state_d = S_RUN;
            end
            S_RUN: begin
                if (take_src) begin
                    state_d = S_RUN;
                end else if (eoi_ok && !nmi_active_q) begin
                    state_d = S_TAIL;
                end
            end
            S_TAIL: begin
                if (take_src) begin
                    state_d = S_RUN;
                end else if (!irq_valid) begin
                    state_d = (depth == DW'(1)) ? S_IDLE : S_RUN;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // outputs and stack control
    always_comb begin
        floor_en  = 1'b0;
        floor_lvl = '0;
        block     = nmi_active_q;
        push      = 1'b0;
        pop       = 1'b0;
        replace   = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                push = take_src;
            end
            S_RUN: begin
                floor_en  = 1'b1;
                floor_lvl = top_lvl;
                block     = nmi_active_q || full;
                push      = take_src;
            end
            S_TAIL: begin
                floor_en  = (depth > DW'(1));
                floor_lvl = below_lvl;
                replace   = take_src;
                pop       = !nmi_pend_q && !win_valid;
            end
            default: ;
        endcase
    end

    assign irq_valid  = nmi_pend_q || win_valid;
    assign irq_vector = nmi_pend_q ? VW'(NMI_VEC) : (win_valid ? VW'(win_idx) : '0);
    assign irq_tail   = (state_q == S_TAIL) && win_valid && !nmi_pend_q;
    assign nest_depth = depth;

endmodule

// File: rtl/irq_nest_checker.sv
module irq_nest_checker #(
    parameter int DEPTH   = 4,
    parameter int VW      = 6,
    parameter int DW      = 3,
    parameter int NMI_VEC = 34
) (
    input logic          clk,
    input logic          rst_n,
    input logic          irq_valid,
    input logic [VW-1:0] irq_vector,
    input logic          irq_tail,
    input logic          irq_ack,
    input logic          irq_eoi,
    input logic          nmi,
    input logic [DW-1:0] nest_depth,
    input logic [2:0]    win_lvl,
    input logic [2:0]    top_lvl,
    input logic          nmi_active
);

    assert_depth_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        nest_depth <= DW'(DEPTH));

    assert_full_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (nest_depth == DW'(DEPTH)) && !irq_tail && irq_valid |-> irq_vector == VW'(NMI_VEC));

    assert_preempt_above_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid && !irq_tail && (irq_vector != VW'(NMI_VEC)) && (nest_depth != '0)
        |-> win_lvl > top_lvl);

    assert_ack_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack && irq_valid && !irq_tail && (irq_vector != VW'(NMI_VEC))
        |=> nest_depth == $past(nest_depth) + DW'(1));

    assert_eoi_no_grow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_eoi && !irq_ack |=> nest_depth <= $past(nest_depth));

    assert_tail_keeps_depth_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tail && irq_ack |=> $stable(nest_depth));

    assert_nmi_presented_R9: assert property (@(posedge clk) disable iff (!rst_n)
        nmi |=> irq_valid && (irq_vector == VW'(NMI_VEC)));

    assert_nmi_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_active && irq_valid |-> irq_vector == VW'(NMI_VEC));

endmodule

bind irq_nest_ctrl irq_nest_checker #(
    .DEPTH   (DEPTH),
    .VW      (VW),
    .DW      (DW),
    .NMI_VEC (NMI_VEC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_valid  (irq_valid),
    .irq_vector (irq_vector),
    .irq_tail   (irq_tail),
    .irq_ack    (irq_ack),
    .irq_eoi    (irq_eoi),
    .nmi        (nmi),
    .nest_depth (nest_depth),
    .win_lvl    (win_lvl),
    .top_lvl    (top_lvl),
    .nmi_active (nmi_active_q)
);

// File: tb/irq_nest_ctrl_test.sv
module irq_nest_ctrl_test;

    localparam int NSRC = 34;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ext_irq = '0;
    logic        timer_irq = 1'b0;
    logic        nmi = 1'b0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        irq_valid;
    logic [5:0]  irq_vector;
    logic        irq_tail;
    logic        irq_ack = 1'b0;
    logic        irq_eoi = 1'b0;
    logic [2:0]  nest_depth;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    irq_nest_ctrl uut (
        .clk(clk), .rst_n(rst_n), .ext_irq(ext_irq), .timer_irq(timer_irq), .nmi(nmi),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_valid(irq_valid), .irq_vector(irq_vector), .irq_tail(irq_tail),
        .irq_ack(irq_ack), .irq_eoi(irq_eoi), .nest_depth(nest_depth)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; ext_irq = '0; timer_irq = 1'b0; nmi = 1'b0;
        reg_wr = 1'b0; irq_ack = 1'b0; irq_eoi = 1'b0;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        reg_addr = 6'(a); reg_wdata = d; reg_wr = 1'b1;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        reg_addr = 6'(a);
        #1;
        d = reg_rdata;
    endtask

    task automatic ack();
        irq_ack = 1'b1; step(); irq_ack = 1'b0;
    endtask

    task automatic eoi();
        irq_eoi = 1'b1; step(); irq_eoi = 1'b0;
    endtask

    // expected winner at an idle controller: -1 if none
    function automatic int exp_winner(input logic [7:0] c [NSRC]);
        int w = -1;
        for (int i = 0; i < NSRC; i++) begin
            if (c[i][7] && c[i][6]) begin
                if (w < 0 || c[i][5:3] > c[w][5:3] ||
                    (c[i][5:3] == c[w][5:3] && c[i][2:0] > c[w][2:0])) w = i;
            end
        end
        return w;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired (all requirements)");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [7:0] cfgs [NSRC];
        int w;
        void'($urandom(32'd20240607));

        do_reset();
        // R13 reset state
        chk("R13 valid", irq_valid, 0);
        chk("R13 depth", nest_depth, 0);
        rd(5, d); chk("R13 reg", d, 8'h00);

        // R11 register map
        wr(3, 8'h2D); rd(3, d); chk("R11 readback", d, 8'h2D);
        wr(40, 8'hFF); rd(40, d); chk("R11 out of range", d, 8'h00);
        wr(3, 8'h00);

        // R1 external line 7: en, lvl 2, pri 1
        wr(7, 8'h51);
        ext_irq[7] = 1'b1; step(); ext_irq[7] = 1'b0;
        rd(7, d); chk("R1 pending set", d, 8'hD1);
        chk("R1 vector", irq_vector, 7);
        ack();
        chk("R5 depth", nest_depth, 1);
        rd(7, d); chk("R5 pending cleared", d, 8'h51);

        // R4 equal and zero level do not preempt
        wr(9, 8'hD7);   // lvl 2 pri 7
        wr(10, 8'hC0);  // lvl 0
        chk("R4 no preempt", irq_valid, 0);
        wr(11, 8'hD8);  // lvl 3
        chk("R4 higher preempts", irq_vector, 11);
        ack();
        chk("R5 nested depth", nest_depth, 2);

        // R7 / R8 end of handler sequence
        eoi();
        chk("R8 no chain above floor", irq_valid, 0);
        step();
        chk("R7 pop", nest_depth, 1);
        eoi();
        chk("R8 tail vector", irq_vector, 9);
        chk("R8 tail flag", irq_tail, 1);
        ack();
        chk("R8 depth kept", nest_depth, 1);
        chk("R4 level0 blocked", irq_valid, 0);
        eoi();
        chk("R8 tail level0", irq_vector, 10);
        ack();
        eoi(); step();
        chk("R7 unwound", nest_depth, 0);

        // R3 / R12 / R2 / timer
        do_reset();
        wr(3, 8'hCA); wr(5, 8'hCD);
        chk("R3 priority", irq_vector, 5);
        wr(3, 8'hCF);
        chk("R12 runtime priority", irq_vector, 3);
        wr(3, 8'hCD);
        chk("R3 index tie", irq_vector, 3);
        wr(5, 8'hD0);
        chk("R3 level beats priority", irq_vector, 5);
        wr(5, 8'h90);
        chk("R2 disabled skipped", irq_vector, 3);
        rd(5, d); chk("R2 pending kept", d, 8'h90);
        wr(3, 8'h8D);
        chk("R2 none enabled", irq_valid, 0);
        wr(33, 8'h40);
        timer_irq = 1'b1; step(); timer_irq = 1'b0;
        chk("R1 timer", irq_vector, 33);
        wr(33, 8'h00);
        wr(32, 8'hC1);
        chk("R1 software", irq_vector, 32);

        // R6 / R9 / R10
        do_reset();
        for (int k = 0; k < 4; k++) begin
            wr(20 + k, 8'(8'hC0 | ((k + 1) << 3)));
            chk("R4 nest chain", irq_vector, 20 + k);
            ack();
        end
        chk("R6 full depth", nest_depth, 4);
        wr(24, 8'hF8);
        chk("R6 full blocks", irq_valid, 0);
        nmi = 1'b1; step(); nmi = 1'b0;
        chk("R9 nmi vector", irq_vector, 34);
        ack();
        chk("R10 stack untouched", nest_depth, 4);
        chk("R10 blocked", irq_valid, 0);
        eoi();
        chk("R10 eoi keeps stack", nest_depth, 4);
        eoi();
        chk("R8 tail at full", irq_vector, 24);
        chk("R8 tail flag full", irq_tail, 1);
        ack();
        chk("R8 depth full kept", nest_depth, 4);

        // R3 random arbitration
        do_reset();
        for (int it = 0; it < 40; it++) begin
            for (int i = 0; i < NSRC; i++) begin
                cfgs[i] = 8'($urandom);
                if (($urandom % 3) == 0) cfgs[i][7] = 1'b0;
                wr(i, cfgs[i]);
            end
            w = exp_winner(cfgs);
            chk("R3 random valid", irq_valid, (w >= 0) ? 1 : 0);
            if (w >= 0) chk("R3 random vector", irq_vector, w);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule